// File: doc/BRIEF.md
# Three-Way LRU Byte Cache

This block is a small physically addressed data cache for a processor with a five-bit, byte-addressable address space. It stores two-byte lines in three ways across four sets, for 24 bytes of data in total. Each line has a two-bit tag, a valid flag and a dirty flag. The processor sends one read or one byte write at a time. The cache answers with a single-cycle response that reports hit or miss and returns the addressed byte.

On a miss the cache fetches the whole line from a backing memory over a request/acknowledge handshake. When the line it must replace is dirty, it first writes that victim back to memory. Replacement is exact least-recently-used within each set. The recency order of the three ways in a set is held as one three-bit code that names one of the six possible orderings. The design does not keep a separate age counter per line.

Top module: `lru3_cache`

## Requirements
- R1: Address bit 0 selects the byte within a line, bits [2:1] select the set and bits [4:3] are the tag. The memory line address is {tag, set} (4 bits). A line on the memory data bus carries byte 0 in bits [7:0] and byte 1 in bits [15:8].
- R2: While reset is asserted and after it is released, every line is invalid, req_ready is high, and resp_valid and mem_req are low.
- R3: A hit raises resp_valid for exactly one cycle, with resp_hit high, on the first clock edge after the edge that accepted the request.
- R4: On a miss with a clean or empty victim, a fill request (mem_req high, mem_write low) starts on the edge after acceptance. The response, with resp_hit low, arrives on the edge that samples mem_ack.
- R5: A miss fills the lowest-numbered invalid way of the set. Only when all three ways are valid does it replace the least recently used way.
- R6: A dirty victim is first written back with mem_write high, the victim's own line address and its data. The fill of the new line follows the write-back acknowledge.
- R7: A write hit updates the byte and marks the line dirty. A write miss fills the line, then merges the byte and marks it dirty. resp_rdata returns the addressed byte as it stands after the access.
- R8: Every access, hit or fill, makes the touched way the most recently used in its set.
- R9: Each set's recency state is a three-bit code. Only the six values 0 to 5 ever occur.
- R10: req_ready stays low from the accepting edge until the response. mem_req, mem_write and mem_addr hold steady until mem_ack is sampled.
- R11: From reset, the read byte-address stream 5,2,0,4,25,9,1,25,16,9,1 yields miss,miss,miss,hit,miss,miss,hit,hit,miss,miss,miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = byte write, 0 = read |
| req_addr | input | 5 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Cache idle, a request is accepted on this edge |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Request hit in the cache |
| resp_rdata | output | 8 | Addressed byte after the access |
| mem_req | output | 1 | Memory transfer requested |
| mem_write | output | 1 | 1 = write-back, 0 = line fill |
| mem_addr | output | 4 | Line address {tag, set} |
| mem_wdata | output | 16 | Victim line being written back |
| mem_ack | input | 1 | Memory completes the transfer this edge |
| mem_rdata | input | 16 | Fill line, valid with mem_ack |

## Verification
A hit answers one edge after acceptance. With the bench memory acknowledging in the cycle after each request, a clean miss answers two edges after acceptance and a dirty miss answers four. The behavioural model computes the expected latency, hit flag and byte for each access before it is issued. After acceptance the bench samples on every falling edge. resp_valid must be low and req_ready low on every earlier edge, and both must be high exactly on the predicted one. The memory side compares each write-back and fill address and each victim's data against queues that the model fills in the order it expects.

// File: rtl/lru3_cache.sv
module lru3_cache (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_addr,
  input  logic [7:0]  req_wdata,
  output logic        req_ready,
  output logic        resp_valid,
  output logic        resp_hit,
  output logic [7:0]  resp_rdata,
  output logic        mem_req,
  output logic        mem_write,
  output logic [3:0]  mem_addr,
  output logic [15:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata
);
  localparam int WAYS = 3;
  localparam int SETS = 4;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WB, S_FILL} st_t;

  st_t st_q;
  logic       wr_q;
  logic [4:0] addr_q;
  logic [7:0] wd_q;
  logic [1:0] vic_q;
  logic [SETS-1:0][WAYS-1:0]       vld_q, drt_q;
  logic [SETS-1:0][WAYS-1:0][1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][15:0] dat_q;
  logic [SETS-1:0][2:0]            lru_q;

  wire [1:0] set_i = addr_q[2:1];
  wire [1:0] tag_i = addr_q[4:3];
  wire       bsel  = addr_q[0];

  function automatic logic [1:0] lo_of(input logic [1:0] m);
    return (m == 2'd0) ? 2'd1 : 2'd0;
  endfunction
  function automatic logic [1:0] hi_of(input logic [1:0] m);
    return (m == 2'd2) ? 2'd1 : 2'd2;
  endfunction
  function automatic logic [1:0] lru_of(input logic [2:0] c);
    return c[0] ? lo_of(c[2:1]) : hi_of(c[2:1]);
  endfunction
  function automatic logic [2:0] touch(input logic [2:0] c, input logic [1:0] w);
    if (c[2:1] == w) return c;
    return {w, c[2:1] == hi_of(w)};
  endfunction
  function automatic logic [15:0] merge(input logic [15:0] l, input logic b, input logic [7:0] d);
    return b ? {d, l[7:0]} : {l[15:8], d};
  endfunction

  logic [2:0] hitv;
  logic [1:0] hit_way, victim;
  always_comb begin
    for (int w = 0; w < WAYS; w++)
      hitv[w] = vld_q[set_i][w] && (tag_q[set_i][w] == tag_i);
    hit_way = hitv[0] ? 2'd0 : hitv[1] ? 2'd1 : 2'd2;
    if (!vld_q[set_i][0])      victim = 2'd0;
    else if (!vld_q[set_i][1]) victim = 2'd1;
    else if (!vld_q[set_i][2]) victim = 2'd2;
    else                       victim = lru_of(lru_q[set_i]);
  end

  wire [15:0] hit_line  = dat_q[set_i][hit_way];
  wire [15:0] hit_new   = wr_q ? merge(hit_line, bsel, wd_q) : hit_line;
  wire [15:0] fill_line = wr_q ? merge(mem_rdata, bsel, wd_q) : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      wd_q       <= '0;
      vic_q      <= '0;
      vld_q      <= '0;
      drt_q      <= '0;
      tag_q      <= '0;
      dat_q      <= '0;
      lru_q      <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          wr_q   <= req_write;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          st_q   <= S_LOOK;
        end
        S_LOOK: if (|hitv) begin
          dat_q[set_i][hit_way] <= hit_new;
          if (wr_q) drt_q[set_i][hit_way] <= 1'b1;
          lru_q[set_i] <= touch(lru_q[set_i], hit_way);
          resp_valid   <= 1'b1;
          resp_hit     <= 1'b1;
          resp_rdata   <= bsel ? hit_new[15:8] : hit_new[7:0];
          st_q         <= S_IDLE;
        end else begin
          vic_q <= victim;
          st_q  <= (vld_q[set_i][victim] && drt_q[set_i][victim]) ? S_WB : S_FILL;
        end
        S_WB: if (mem_ack) begin
          drt_q[set_i][vic_q] <= 1'b0;
          st_q <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          dat_q[set_i][vic_q] <= fill_line;
          tag_q[set_i][vic_q] <= tag_i;
          vld_q[set_i][vic_q] <= 1'b1;
          drt_q[set_i][vic_q] <= wr_q;
          lru_q[set_i] <= touch(lru_q[set_i], vic_q);
          resp_valid   <= 1'b1;
          resp_hit     <= 1'b0;
          resp_rdata   <= bsel ? fill_line[15:8] : fill_line[7:0];
          st_q         <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign mem_req   = (st_q == S_WB) || (st_q == S_FILL);
  assign mem_write = (st_q == S_WB);
  assign mem_addr  = (st_q == S_WB) ? {tag_q[set_i][vic_q], set_i} : {tag_i, set_i};
  assign mem_wdata = dat_q[set_i][vic_q];
endmodule

// File: rtl/lru3_cache_chk.sv
module lru3_cache_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            mem_req,
  input logic            mem_write,
  input logic            mem_ack,
  input logic [3:0]      mem_addr,
  input logic [3:0][2:0] lru_codes
);
  p_hit_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  p_resp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);
  p_accept_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));
  p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_write && mem_ack) |=> (mem_req && !mem_write));
  p_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lru_codes[0] < 3'd6) && (lru_codes[1] < 3'd6) && (lru_codes[2] < 3'd6) && (lru_codes[3] < 3'd6));
endmodule

bind lru3_cache lru3_cache_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .mem_req(mem_req), .mem_write(mem_write),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .lru_codes(lru_q)
);

// File: tb/lru3_cache_tb_top.sv
`timescale 1ns/1ps
module lru3_cache_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, req_valid, req_write, req_ready, resp_valid, resp_hit;
  logic [4:0]  req_addr;
  logic [7:0]  req_wdata, resp_rdata;
  logic        mem_req, mem_write, mem_ack;
  logic [3:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  lru3_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  logic [15:0] mem [16];
  logic [15:0] ref_mem [16];
  logic [1:0]  m_tag [4][3];
  bit          m_drt [4][3];
  logic [15:0] m_dat [4][3];
  int          m_n [4];
  int exp_wb_a[$], exp_wb_d[$], exp_fl_a[$];

  task automatic model(input bit wr, input logic [4:0] a, input logic [7:0] wd,
                       output bit hit, output logic [7:0] rd, output int lat);
    int s, idx, top;
    logic [1:0] t, et;
    bit ed;
    logic [15:0] el;
    s = int'(a[2:1]); t = a[4:3]; idx = -1;
    for (int i = 0; i < m_n[s]; i++) if (m_tag[s][i] == t) idx = i;
    if (idx >= 0) begin
      hit = 1; lat = 1; top = idx;
      et = m_tag[s][idx]; ed = m_drt[s][idx]; el = m_dat[s][idx];
    end else begin
      hit = 0; lat = 2;
      if (m_n[s] == 3) begin
        top = 2;
        if (m_drt[s][2]) begin
          exp_wb_a.push_back(int'({m_tag[s][2], a[2:1]}));
          exp_wb_d.push_back(int'(m_dat[s][2]));
          ref_mem[{m_tag[s][2], a[2:1]}] = m_dat[s][2];
          lat = 4;
        end
      end else begin
        top = m_n[s];
        m_n[s]++;
      end
      et = t; ed = 0; el = ref_mem[{t, a[2:1]}];
      exp_fl_a.push_back(int'({t, a[2:1]}));
    end
    for (int j = top; j > 0; j--) begin
      m_tag[s][j] = m_tag[s][j-1]; m_drt[s][j] = m_drt[s][j-1]; m_dat[s][j] = m_dat[s][j-1];
    end
    if (wr) begin
      if (a[0]) el[15:8] = wd; else el[7:0] = wd;
      ed = 1;
    end
    m_tag[s][0] = et; m_drt[s][0] = ed; m_dat[s][0] = el;
    rd = a[0] ? el[15:8] : el[7:0];
  endtask

  task automatic access(input bit wr, input logic [4:0] a, input logic [7:0] wd,
                        input string rq, output bit hit_o);
    bit eh;
    logic [7:0] erd;
    int lat;
    model(wr, a, wd, eh, erd, lat);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      chk(resp_valid == (k == lat), rq, $sformatf("resp_valid edge %0d addr %0d", k, a), int'(resp_valid), int'(k == lat));
      chk(req_ready == (k == lat), "R10", $sformatf("ready edge %0d addr %0d", k, a), int'(req_ready), int'(k == lat));
      if (k == lat) begin
        chk(resp_hit == eh, eh ? "R3" : "R4", $sformatf("hit addr %0d", a), int'(resp_hit), int'(eh));
        chk(resp_rdata == erd, wr ? "R7" : rq, $sformatf("rdata addr %0d", a), int'(resp_rdata), int'(erd));
      end
    end
    hit_o = resp_hit;
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack = 1;
      if (mem_write) begin
        if (exp_wb_a.size() == 0) chk(0, "R6", "unexpected write-back", int'(mem_addr), -1);
        else begin
          chk(int'(mem_addr) == exp_wb_a[0], "R6", "write-back address", int'(mem_addr), exp_wb_a[0]);
          chk(int'(mem_wdata) == exp_wb_d[0], "R6", "write-back data", int'(mem_wdata), exp_wb_d[0]);
          void'(exp_wb_a.pop_front()); void'(exp_wb_d.pop_front());
        end
        mem[mem_addr] = mem_wdata;
      end else begin
        if (exp_fl_a.size() == 0) chk(0, "R1", "unexpected fill", int'(mem_addr), -1);
        else begin
          chk(int'(mem_addr) == exp_fl_a[0], "R1", "fill address", int'(mem_addr), exp_fl_a[0]);
          void'(exp_fl_a.pop_front());
        end
        mem_rdata = mem[mem_addr];
      end
    end else mem_ack = 0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int stream [11] = '{5, 2, 0, 4, 25, 9, 1, 25, 16, 9, 1};
    bit gold [11]   = '{0, 0, 0, 1, 0, 0, 1, 1, 0, 0, 0};
    bit h;
    logic [31:0] lcg;
    logic [7:0] b0, b1;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    mem_ack = 0; mem_rdata = 0;
    for (int i = 0; i < 16; i++) begin
      b0 = 8'((2*i) * 5 + 1); b1 = 8'((2*i+1) * 5 + 1);
      mem[i] = {b1, b0}; ref_mem[i] = {b1, b0};
    end
    for (int s = 0; s < 4; s++) m_n[s] = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R2", "reset ready", int'(req_ready), 1);
    chk(resp_valid == 0, "R2", "reset resp_valid", int'(resp_valid), 0);
    chk(mem_req == 0, "R2", "reset mem_req", int'(mem_req), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && mem_req == 0, "R2", "after reset idle", int'(req_ready), 1);

    for (int i = 0; i < 11; i++) begin
      access(0, 5'(stream[i]), 8'h00, "R11", h);
      chk(h == gold[i], "R11", $sformatf("stream outcome %0d", i), int'(h), int'(gold[i]));
    end

    access(1, 5'd3,  8'hA5, "R7", h);
    access(1, 5'd10, 8'h5A, "R7", h);
    access(1, 5'd19, 8'h3C, "R7", h);
    access(1, 5'd3,  8'hC3, "R7", h);
    access(0, 5'd27, 8'h00, "R6", h);
    access(0, 5'd11, 8'h00, "R8", h);
    access(0, 5'd2,  8'h00, "R5", h);
    access(1, 5'd26, 8'h77, "R7", h);
    access(0, 5'd18, 8'h00, "R6", h);
    access(0, 5'd7,  8'h00, "R5", h);
    access(0, 5'd15, 8'h00, "R5", h);
    access(0, 5'd7,  8'h00, "R8", h);
    access(0, 5'd23, 8'h00, "R8", h);
    access(0, 5'd31, 8'h00, "R8", h);
    access(0, 5'd15, 8'h00, "R8", h);

    lcg = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      access(lcg[27], lcg[20:16], lcg[15:8], "R9", h);
    end

    repeat (4) @(negedge clk);
    chk(exp_wb_a.size() == 0, "R6", "pending write-backs", exp_wb_a.size(), 0);
    chk(exp_fl_a.size() == 0, "R4", "pending fills", exp_fl_a.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule